// File: doc/BRIEF.md
# 8b/10b Transmit Coding Stage with Disparity and Bit-Order Overrides

This block sits in front of a serializer on the transmit side of a serial link. On every clock it takes one byte and a control flag and maps the byte onto a 10-bit code group from the standard 8b/10b code. It keeps a running disparity so that the line stays DC balanced. For any word, a caller can also pin the disparity form of the code group to a value of its own choosing. Two transforms follow the encoder before the word leaves the block. The first is an optional reversal of the bit order. The second is a per-word inversion of every bit, which corrects a P/N swap made during board layout.

A bypass input skips the encoder. A raw 8-bit or 10-bit word then goes through the same two transforms. The output is registered, so the word for the serializer appears exactly one clock after the input word. Each output word carries a flag that gives its width. A separate flag marks control bytes that have no valid control code group.

Top module: `pcs_tx_8b10b`

## Requirements
- R1: While `rst_n` is low, `ser_word` is 0, `ser_wide` is 1 and `k_err` is 0. Running disparity starts negative, so the first K28.5 after reset leaves as code group `0011111010` (listed a through j).
- R2: A data byte HGF EDCBA is sent as the standard 8b/10b code group abcdei fghj. Without reversal, `ser_word[0]` carries bit a and `ser_word[9]` carries bit j.
- R3: With no override, the running disparity picks the form of each code group: the RD- form when disparity is negative, the RD+ form when it is positive. Disparity is updated from every encoded group, and each group has 4, 5 or 6 ones.
- R4: With `tx_ctl` high, the byte is sent as a control code group if it is K28.0 to K28.7, K23.7, K27.7, K29.7 or K30.7. For any other byte, `k_err` is 1 with that word's output, and the byte is encoded as a data byte.
- R5: When `frc_disp` is high, `frc_neg` = 1 forces the RD- form and `frc_neg` = 0 forces the RD+ form, whatever the running disparity is. Running disparity then carries on from the group that was actually sent.
- R6: When `rev_order` is high, bit i of the word moves to bit 9-i for a 10-bit word, or to bit 7-i for an 8-bit word.
- R7: When `inv_pol` is high, every active bit of the output word is inverted. Inversion is applied after reversal. It takes effect word by word and has no effect on running disparity.
- R8: When `byp_en` is high, `byp_word` (with `byp_wide` = 1) or `byp_word[7:0]` (with `byp_wide` = 0) passes through the R6 and R7 transforms. `ser_wide` follows `byp_wide`, `ser_word[9:8]` is 0 for 8-bit words, `k_err` is 0, and running disparity holds.
- R9: Each input word produces its output word after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sym | input | 8 | Byte to encode |
| tx_ctl | input | 1 | Byte is a control character |
| frc_disp | input | 1 | Force the disparity form of this word |
| frc_neg | input | 1 | Forced form: 1 = RD-, 0 = RD+ |
| inv_pol | input | 1 | Invert all output bits of this word |
| rev_order | input | 1 | Reverse the bit order of the output word |
| byp_en | input | 1 | Send the raw word and skip the encoder |
| byp_wide | input | 1 | Raw word width: 1 = 10 bits, 0 = 8 bits |
| byp_word | input | 10 | Raw word for bypass |
| ser_word | output | 10 | Word to the serializer, bit 0 sent first |
| ser_wide | output | 1 | Width of `ser_word`: 1 = 10 bits, 0 = 8 bits |
| k_err | output | 1 | Invalid control byte in this word |

## Verification
Every result of this block (the code group, the width flag and the control-error flag) is due exactly one rising edge after its input word is presented, and an override has the same latency. The bench drives each word on a falling edge and compares all three outputs on the next falling edge, against a model that updates its own running disparity in step. Because of this, any latency error, and any disparity update applied to the wrong word, shows up as a mismatch on the following word.

// File: rtl/pcs_tx_pkg.sv
`timescale 1ns/1ps
package pcs_tx_pkg;

  parameter int SYM_W  = 8;
  parameter int GRP_W  = 10;
  localparam int LO_W  = 5;
  localparam int HI_W  = SYM_W - LO_W;
  localparam int S6_W  = 6;
  localparam int S4_W  = GRP_W - S6_W;

  // RD- form of the 6-bit sub-block, bit a in the MSB
  function automatic logic [S6_W-1:0] d6_base(input logic [LO_W-1:0] x);
    logic [S6_W-1:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // RD- form of the 4-bit data sub-block, bit f in the MSB
  function automatic logic [S4_W-1:0] d4_base(input logic [HI_W-1:0] y);
    logic [S4_W-1:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = 4'b1110;
    endcase
    return r;
  endfunction

  // RD- form of the 4-bit sub-block of K28.y
  function automatic logic [S4_W-1:0] k4_base(input logic [HI_W-1:0] y);
    logic [S4_W-1:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b0110;
      3'd2: r = 4'b1010;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b0101;
      3'd6: r = 4'b1001;  default: r = 4'b0111;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcs_tx_enc.sv
`timescale 1ns/1ps
module pcs_tx_enc
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_en,
  input  logic [SYM_W-1:0] sym,
  input  logic             is_ctl,
  input  logic             frc,
  input  logic             frc_neg,
  output logic [GRP_W-1:0] grp,
  output logic             k_bad
);

  logic            rd_neg_q, rd_neg_d;
  logic [LO_W-1:0] x;
  logic [HI_W-1:0] y;
  logic            k28, k_x7, k_ok;
  logic            start_neg, mid_neg, end_neg;
  logic [S6_W-1:0] b6, c6;
  logic [S4_W-1:0] b4, c4;
  logic            flip6, flip4, use_a7;

  always_comb begin
    x         = sym[LO_W-1:0];
    y         = sym[SYM_W-1:LO_W];
    k28       = (x == 5'd28);
    k_x7      = (y == 3'd7) &&
                ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30));
    k_ok      = is_ctl && (k28 || k_x7);
    k_bad     = is_ctl && !k_ok;
    start_neg = frc ? frc_neg : rd_neg_q;

    // 6-bit sub-block
    b6      = (k_ok && k28) ? 6'b001111 : d6_base(x);
    flip6   = ($countones(b6) != 3) || (x == 5'd7);
    c6      = (!start_neg && flip6) ? ~b6 : b6;
    if ($countones(c6) == 3) mid_neg = start_neg;
    else                     mid_neg = ($countones(c6) < 3);

    // 4-bit sub-block
    use_a7 = (y == 3'd7) &&
             ((mid_neg  && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
              (!mid_neg && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))));
    if (k_ok) begin
      b4    = k28 ? k4_base(y) : 4'b0111;
      flip4 = 1'b1;
    end else begin
      b4    = use_a7 ? 4'b0111 : d4_base(y);
      flip4 = ($countones(b4) != 2) || (y == 3'd3);
    end
    c4 = (!mid_neg && flip4) ? ~b4 : b4;
    if ($countones(c4) == 2) end_neg = mid_neg;
    else                     end_neg = ($countones(c4) < 2);

    grp      = {c6, c4};
    rd_neg_d = enc_en ? end_neg : rd_neg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_neg_q <= 1'b1;
    else        rd_neg_q <= rd_neg_d;
  end

  // R3: each sent group is balanced or off by two
  a_r3_disp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    enc_en |-> ($countones(grp) inside {4, 5, 6}));
  // R3: a heavy group leaves disparity positive
  a_r3_rd_after_heavy: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_en && $countones(grp) == 6) |=> !rd_neg_q);
  // R3: a light group leaves disparity negative
  a_r3_rd_after_light: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_en && $countones(grp) == 4) |=> rd_neg_q);
  // R8: bypass words leave disparity untouched
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_en |=> $stable(rd_neg_q));
  // R5: a forced balanced group keeps the forced disparity
  a_r5_forced_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_en && frc && $countones(grp) == 5) |=> (rd_neg_q == $past(frc_neg)));

endmodule

// File: rtl/pcs_tx_xform.sv
`timescale 1ns/1ps
module pcs_tx_xform #(
  parameter int W_WIDE   = 10,
  parameter int W_NARROW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W_WIDE-1:0] word_in,
  input  logic              wide,
  input  logic              rev,
  input  logic              inv,
  output logic [W_WIDE-1:0] word_q,
  output logic              wide_q
);

  logic [W_WIDE-1:0] word_d;

  for (genvar g = 0; g < W_WIDE; g++) begin : g_bit
    logic ord_bit, act;
    if (g < W_NARROW) begin : g_low
      always_comb begin
        act     = 1'b1;
        ord_bit = rev ? (wide ? word_in[W_WIDE-1-g] : word_in[W_NARROW-1-g])
                      : word_in[g];
      end
    end else begin : g_high
      always_comb begin
        act     = wide;
        ord_bit = rev ? word_in[W_WIDE-1-g] : word_in[g];
      end
    end
    assign word_d[g] = act & (ord_bit ^ inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      wide_q <= 1'b1;
    end else begin
      word_q <= word_d;
      wide_q <= wide;
    end
  end

  // R8: narrow words keep their upper bits clear
  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (word_q[W_WIDE-1:W_NARROW] == '0));
  // R7: full inversion of a wide word in natural order
  a_r7_inv_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && inv && !rev) |=> (word_q == ~$past(word_in)));
  // R9: untouched wide word appears one edge later
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !inv && !rev) |=> (word_q == $past(word_in)));

endmodule

// File: rtl/pcs_tx_8b10b.sv
`timescale 1ns/1ps
module pcs_tx_8b10b
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] tx_sym,
  input  logic             tx_ctl,
  input  logic             frc_disp,
  input  logic             frc_neg,
  input  logic             inv_pol,
  input  logic             rev_order,
  input  logic             byp_en,
  input  logic             byp_wide,
  input  logic [GRP_W-1:0] byp_word,
  output logic [GRP_W-1:0] ser_word,
  output logic             ser_wide,
  output logic             k_err
);

  logic [GRP_W-1:0] grp, grp_lsb, raw_word;
  logic             k_bad, raw_wide, k_err_d;

  pcs_tx_enc u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .enc_en  (!byp_en),
    .sym     (tx_sym),
    .is_ctl  (tx_ctl),
    .frc     (frc_disp),
    .frc_neg (frc_neg),
    .grp     (grp),
    .k_bad   (k_bad)
  );

  // code group bit a goes out first
  for (genvar i = 0; i < GRP_W; i++) begin : g_order
    assign grp_lsb[i] = grp[GRP_W-1-i];
  end

  always_comb begin
    if (byp_en) begin
      raw_wide = byp_wide;
      raw_word = byp_wide ? byp_word
                          : {{(GRP_W-SYM_W){1'b0}}, byp_word[SYM_W-1:0]};
    end else begin
      raw_wide = 1'b1;
      raw_word = grp_lsb;
    end
    k_err_d = !byp_en && k_bad;
  end

  pcs_tx_xform #(.W_WIDE(GRP_W), .W_NARROW(SYM_W)) u_xform (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_in (raw_word),
    .wide    (raw_wide),
    .rev     (rev_order),
    .inv     (inv_pol),
    .word_q  (ser_word),
    .wide_q  (ser_wide)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_err <= 1'b0;
    else        k_err <= k_err_d;
  end

  // R4: an error flag only follows an encoded control byte
  a_r4_kerr_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    k_err |-> $past(tx_ctl && !byp_en));
  // R8: encoded words are always ten bits wide
  a_r8_enc_wide: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_en |=> ser_wide);

endmodule

// File: tb/pcs_tx_8b10b_tb_top.sv
`timescale 1ns/1ps
module pcs_tx_8b10b_tb_top;

  localparam time CLK_PER = 8ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_sym;
  logic       tx_ctl, frc_disp, frc_neg, inv_pol, rev_order, byp_en, byp_wide;
  logic [9:0] byp_word;
  logic [9:0] ser_word;
  logic       ser_wide, k_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PER/2) clk = ~clk;

  pcs_tx_8b10b dut_i (
    .clk(clk), .rst_n(rst_n), .tx_sym(tx_sym), .tx_ctl(tx_ctl),
    .frc_disp(frc_disp), .frc_neg(frc_neg), .inv_pol(inv_pol),
    .rev_order(rev_order), .byp_en(byp_en), .byp_wide(byp_wide),
    .byp_word(byp_word), .ser_word(ser_word), .ser_wide(ser_wide),
    .k_err(k_err)
  );

  // reference tables, RD- forms, first-sent bit in the MSB
  logic [5:0] m6 [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                          6'b110101, 6'b101001, 6'b011001, 6'b111000,
                          6'b111001, 6'b100101, 6'b010101, 6'b110100,
                          6'b001101, 6'b101100, 6'b011100, 6'b010111,
                          6'b011011, 6'b100011, 6'b010011, 6'b110010,
                          6'b001011, 6'b101010, 6'b011010, 6'b111010,
                          6'b110011, 6'b100110, 6'b010110, 6'b110110,
                          6'b001110, 6'b101110, 6'b011110, 6'b101011};
  logic [3:0] m4 [8]  = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                          4'b1101, 4'b1010, 4'b0110, 4'b1110};
  logic [3:0] mk4 [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                          4'b1101, 4'b0101, 4'b1001, 4'b0111};

  bit m_neg = 1'b1;

  // pick a sub-block form by its disparity, flip the state when unbalanced
  function automatic logic [5:0] choose(input int n, input logic [5:0] c,
                                        input bit alt_neutral, inout bit neg);
    int         ones;
    logic [5:0] msk, cc;
    ones = $countones(c);
    msk  = (n == 6) ? 6'h3f : 6'h0f;
    cc   = ~c & msk;
    if (2 * ones == n) return (alt_neutral && !neg) ? cc : c;
    if (neg) choose = (2 * ones > n) ? c : cc;
    else     choose = (2 * ones > n) ? cc : c;
    neg = !neg;
  endfunction

  function automatic logic [9:0] ref_enc(input logic [7:0] b, input bit k,
                                         input bit f, input bit fn,
                                         output bit err);
    int         x, y;
    bit         kv, neg, a7, alt;
    logic [5:0] c6, c4;
    logic [3:0] s4;
    logic [9:0] code, w;
    x   = int'(b[4:0]);
    y   = int'(b[7:5]);
    kv  = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
    err = k && !kv;
    neg = f ? fn : m_neg;
    c6  = choose(6, (kv && x == 28) ? 6'b001111 : m6[x], x == 7, neg);
    if (kv) begin
      s4  = (x == 28) ? mk4[y] : 4'b0111;
      alt = (x == 28);
    end else begin
      a7  = (y == 7) && ((neg && (x == 17 || x == 18 || x == 20)) ||
                         (!neg && (x == 11 || x == 13 || x == 14)));
      s4  = a7 ? 4'b0111 : m4[y];
      alt = (y == 3);
    end
    c4    = choose(4, {2'b00, s4}, alt, neg);
    m_neg = neg;
    code  = {c6, c4[3:0]};
    for (int i = 0; i < 10; i++) w[i] = code[9 - i];
    return w;
  endfunction

  function automatic logic [9:0] ref_xf(input logic [9:0] w, input bit wide,
                                        input bit rev, input bit inv);
    int         n;
    logic [9:0] r;
    n = wide ? 10 : 8;
    r = '0;
    for (int i = 0; i < n; i++) r[i] = (rev ? w[n - 1 - i] : w[i]) ^ inv;
    return r;
  endfunction

  // drive one word at a falling edge, compare at the next falling edge
  task automatic step(input logic [7:0] sym, input bit ctl, input bit f,
                      input bit fn, input bit inv, input bit rev,
                      input bit byp, input bit bw, input logic [9:0] bword,
                      input string req);
    logic [9:0] e_word, raw;
    bit         e_wide, e_err, err;
    tx_sym = sym; tx_ctl = ctl; frc_disp = f; frc_neg = fn;
    inv_pol = inv; rev_order = rev; byp_en = byp; byp_wide = bw;
    byp_word = bword;
    if (byp) begin
      raw    = bw ? bword : {2'b00, bword[7:0]};
      e_wide = bw;
      e_err  = 1'b0;
    end else begin
      raw    = ref_enc(sym, ctl, f, fn, err);
      e_wide = 1'b1;
      e_err  = err;
    end
    e_word = ref_xf(raw, e_wide, rev, inv);
    @(negedge clk);
    checks++;
    if (ser_word !== e_word || ser_wide !== e_wide || k_err !== e_err) begin
      fails++;
      $display("FAIL %s: word=%b wide=%b kerr=%b, expected word=%b wide=%b kerr=%b",
               req, ser_word, ser_wide, k_err, e_word, e_wide, e_err);
    end
  endtask

  task automatic enc(input logic [7:0] sym, input bit ctl, input string req);
    step(sym, ctl, 0, 0, 0, 0, 0, 1, '0, req);
  endtask

  task automatic hard_check(input logic [9:0] exp_w, input string req);
    checks++;
    if (ser_word !== exp_w) begin
      fails++;
      $display("FAIL %s: word=%b, expected word=%b", req, ser_word, exp_w);
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_sym = '0; tx_ctl = 0; frc_disp = 0; frc_neg = 0; inv_pol = 0;
    rev_order = 0; byp_en = 0; byp_wide = 1; byp_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    checks++;
    if (ser_word !== 10'd0 || ser_wide !== 1'b1 || k_err !== 1'b0) begin
      fails++;
      $display("FAIL R1: word=%b wide=%b kerr=%b, expected word=0 wide=1 kerr=0",
               ser_word, ser_wide, k_err);
    end
    rst_n = 1'b1;

    // R1/R3: K28.5 after reset in RD- form, then in RD+ form
    enc(8'hBC, 1, "R1 first K28.5");
    hard_check(10'b0101111100, "R1 K28.5 RD- literal");
    enc(8'hBC, 1, "R3 second K28.5");
    hard_check(10'b1010000011, "R3 K28.5 RD+ literal");

    // R2/R3/R9: every data byte, twice so each disparity state is reached
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 256; b++) enc(8'(b + r * 37), 0, "R2 R3 data sweep");

    // R4: all valid control codes
    for (int r = 0; r < 2; r++) begin
      for (int y = 0; y < 8; y++) enc({3'(y), 5'd28}, 1, "R4 K28.y");
      enc({3'd7, 5'd23}, 1, "R4 K23.7");
      enc({3'd7, 5'd27}, 1, "R4 K27.7");
      enc({3'd7, 5'd29}, 1, "R4 K29.7");
      enc({3'd7, 5'd30}, 1, "R4 K30.7");
    end
    // R4: invalid control bytes raise the flag
    enc({3'd3, 5'd5}, 1, "R4 invalid K5.3");
    enc({3'd0, 5'd23}, 1, "R4 invalid K23.0");
    enc({3'd7, 5'd31}, 1, "R4 invalid K31.7");
    enc(8'h4A, 1, "R4 invalid K10.2");

    // R5: forced disparity, both values, against both running states
    for (int i = 0; i < 64; i++)
      step(8'($urandom), ($urandom % 4) == 0, 1, 1'($urandom), 0, 0, 0, 1, '0,
           "R5 forced form");
    step(8'hBC, 1, 1, 1, 0, 0, 0, 1, '0, "R5 forced RD- K28.5");
    hard_check(10'b0101111100, "R5 forced RD- K28.5 literal");
    step(8'hBC, 1, 1, 0, 0, 0, 0, 1, '0, "R5 forced RD+ K28.5");
    hard_check(10'b1010000011, "R5 forced RD+ K28.5 literal");
    for (int i = 0; i < 8; i++)
      step(8'($urandom), 0, i[0], 1'($urandom), 0, 0, 0, 1, '0, "R5 mixed force");

    // R6: bit reversal on encoded words
    for (int i = 0; i < 40; i++)
      step(8'($urandom), 0, 0, 0, 0, 1, 0, 1, '0, "R6 reversed");
    step(8'hBC, 1, 0, 0, 0, 1, 0, 1, '0, "R6 reversed K28.5");

    // R7: inversion toggled word by word, with and without reversal
    for (int i = 0; i < 60; i++)
      step(8'($urandom), 0, 0, 0, i[0], i[2], 0, 1, '0, "R7 dynamic invert");

    // R8: bypass words of both widths, interleaved with encoded words
    for (int i = 0; i < 60; i++) begin
      step(8'($urandom), 1'($urandom), 0, 0, 1'($urandom), 1'($urandom), 1,
           1'($urandom), 10'($urandom), "R8 bypass");
      if (i % 3 == 0) enc(8'($urandom), 0, "R8 disparity held over bypass");
    end
    step(8'h00, 1, 0, 0, 1, 0, 1, 0, 10'h3FF, "R8 narrow invert");
    hard_check(10'h0FF & ~10'h0FF, "R8 narrow inverted literal");
    step(8'h00, 0, 0, 0, 0, 1, 1, 0, 10'h301, "R8 narrow reverse");
    hard_check(10'h080, "R8 narrow reversed literal");

    // R9: long mixed run, all controls random per word
    for (int i = 0; i < 400; i++)
      step(8'($urandom), ($urandom % 5) == 0, ($urandom % 6) == 0, 1'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 7) == 0, 1'($urandom),
           10'($urandom), "R9 mixed stream");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule